// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple single-cycle memory-mapped bus. The bus has a 32-bit data path and word-aligned addresses. The port holds a per-pin direction register and an output data register. Its outputs drive the pad output values and the pad output enables. Pad inputs pass through a two-flop synchronizer before the bus reads them.

Data accesses use a mask carried in the address. Address bits [9:2] select which pins a data read or write touches, so software can change one pin, or any group of pins, with a single store and no read-modify-write. The data window covers byte offsets 0x000 to 0x3FC. A write to a pin configured as input is dropped. When that pin later becomes an output, it keeps its old output value until it is written again.

Decode is a small enumerated access kind: NONE, DATA or DIR. There is no sequencing state, because every access completes in the cycle it is presented. There are no transitions beyond that per-cycle decode.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, and while reset is held, the direction and output data registers are 0. Therefore pad_oe = 0x00 and pad_out = 0x00, and a read of the direction offset returns 0.
- R2: pad_oe[n] equals direction bit n, and pad_out[n] equals output data bit n, at all times.
- R3: A write to byte offset 0x400 loads bus_wdata[7:0] into the direction register (1 = output, 0 = input) at the clock edge. A read of 0x400 returns the direction register in bits [7:0] and zeros above.
- R4: A data write (offset bits [11:10] = 00) changes only those output bits whose mask bit, address bit [n+2], is 1. All other output bits keep their value. With no data write, the output register holds.
- R5: A data write to a pin that is currently an input has no effect. After the pin is switched to output, it drives its earlier value until it is rewritten.
- R6: On a data read, bit n is 0 when address bit [n+2] is 0, and bits [31:8] are 0.
- R7: On a data read with the mask bit set, an output pin returns its driven value. An input pin returns pad_in after two clock edges of synchronization: a change is invisible after one edge and visible after two.
- R8: Reads of any offset other than the data window and 0x400 return 0, and writes to them change nothing. bus_rdata is 0 whenever bus_sel is low or the access is a write.
- R9: A read returns its data combinationally in the same cycle as the request, with no wait state. A write takes effect at the rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [9:2] are the data mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The assertions take for granted that the bus inputs are known and stable for the whole cycle after reset is released, and that one access is presented per cycle. pad_in may change at any moment, so no assertion ties a read to a particular pad_in sample. The stimulus changes bus signals only on the falling clock edge. Before any read that expects an input level, it holds pad_in steady for at least three edges, except in the one test that probes the synchronizer latency on purpose.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    // Kind of bus access decoded from the address
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
`timescale 1ns/1ps
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output logic [NPINS-1:0]  mask
);
    localparam int MASK_LSB = 2;
    localparam int WIN_LSB  = NPINS + MASK_LSB;
    localparam int WORD_W   = ADDR_W - MASK_LSB;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << NPINS;

    logic in_window;
    logic at_dir;

    always_comb begin
        in_window = (addr[ADDR_W-1:WIN_LSB] == '0);
        at_dir    = (addr[ADDR_W-1:MASK_LSB] == DIR_WORD);
        if (in_window)   kind = ACC_DATA;
        else if (at_dir) kind = ACC_DIR;
        else             kind = ACC_NONE;
    end

    assign mask = addr[WIN_LSB-1:MASK_LSB];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_data,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q
);
    logic [NPINS-1:0] out_d;

    // Per-pin write enable: selected by the mask and configured as output
    always_comb begin
        for (int n = 0; n < NPINS; n++) begin
            out_d[n] = (wr_data && mask[n] && dir_q[n]) ? wdata[n] : out_q[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            out_q <= out_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (dir_q == '0 && out_q == '0)); // R1
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_dir |=> dir_q == $past(wdata)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_data |=> $stable(out_q)); // R4
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> ((out_q ^ $past(out_q)) & ~($past(mask) & $past(dir_q))) == '0); // R5
endmodule

// File: rtl/gpio_masked_port.sv
`timescale 1ns/1ps
module gpio_masked_port
    import gpio_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    localparam int SYNC_STAGES = 2;

    acc_e             kind;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] level;
    logic             wr_dir;
    logic             wr_data;
    logic             rd_en;

    gpio_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .mask (mask)
    );

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    assign wr_dir  = bus_sel && bus_wr && (kind == ACC_DIR);
    assign wr_data = bus_sel && bus_wr && (kind == ACC_DATA);
    assign rd_en   = bus_sel && !bus_wr;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_data (wr_data),
        .wdata   (bus_wdata[NPINS-1:0]),
        .mask    (mask),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    // Output pins read back their driven value, input pins the synchronized level
    assign level = (dir_q & out_q) | (~dir_q & pin_sync);

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (kind)
                ACC_DATA: bus_rdata[NPINS-1:0] = level & mask;
                ACC_DIR:  bus_rdata[NPINS-1:0] = dir_q;
                ACC_NONE: bus_rdata = '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q;

    AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_DATA) |-> (bus_rdata[NPINS-1:0] & ~bus_addr[NPINS+1:2]) == '0); // R6
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NPINS] == '0); // R6
    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || kind == ACC_NONE) |-> bus_rdata == '0); // R8
    AST_RD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_DIR) |-> bus_rdata[NPINS-1:0] == pad_oe); // R3
    AST_RD_OUTPUT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_DATA) |-> ((bus_rdata[NPINS-1:0] ^ pad_out) & pad_oe & mask) == '0); // R7
endmodule

// File: tb/test_gpio_masked_port.sv
`timescale 1ns/1ps
module test_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_masked_port i_gpio_masked_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: presents a read and pushes the expected word for the monitor
    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        #1.5;
        bus_sel = 1'b0;
    endtask

    // Monitor: compares read data in the request cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        settle(3);
        check("R1 reset pad_oe", {24'h0, pad_oe}, 32'h0);
        check("R1 reset pad_out", {24'h0, pad_out}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h400, 32'h0, "R1 dir after reset");

        bus_write(12'h400, 32'hFFFF_FFF0);
        check("R2 R3 pad_oe after dir write", {24'h0, pad_oe}, 32'hF0);
        bus_read(12'h400, 32'hF0, "R3 dir readback");

        bus_write(12'h3FC, 32'hFF);
        check("R5 R2 write to inputs dropped", {24'h0, pad_out}, 32'hF0);

        bus_write(12'h040, 32'h00);
        check("R4 single pin mask", {24'h0, pad_out}, 32'hE0);
        bus_write(12'h300, 32'h00);
        check("R4 pins 6,7 cleared", {24'h0, pad_out}, 32'h20);
        bus_write(12'h200, 32'hFF);
        check("R4 pin 7 set", {24'h0, pad_out}, 32'hA0);

        pad_in = 8'h0A;
        settle(3);
        bus_read(12'h3FC, 32'hAA, "R7 mixed read");
        bus_read(12'h03C, 32'h0A, "R6 low nibble mask");
        bus_read(12'h008, 32'h02, "R6 single input pin");
        bus_read(12'h000, 32'h00, "R6 empty mask");

        bus_write(12'h400, 32'hFF);
        check("R5 old value after turning output", {24'h0, pad_out}, 32'hA0);
        bus_write(12'h03C, 32'h05);
        check("R5 rewritten after turning output", {24'h0, pad_out}, 32'hA5);
        bus_read(12'h3FC, 32'hA5, "R7 output pins read driven value");

        bus_write(12'h404, 32'h00);
        check("R8 write to unmapped keeps dir", {24'h0, pad_oe}, 32'hFF);
        bus_write(12'h800, 32'h00);
        check("R8 write to unmapped keeps data", {24'h0, pad_out}, 32'hA5);
        bus_read(12'h404, 32'h0, "R8 unmapped read");
        bus_read(12'hBFC, 32'h0, "R8 unmapped high read");

        bus_write(12'h400, 32'h00);
        pad_in = 8'h00;
        settle(3);
        @(negedge clk);
        pad_in = 8'h55;
        bus_read(12'h3FC, 32'h00, "R7 invisible after one edge");
        bus_read(12'h3FC, 32'h55, "R7 visible after two edges");
        bus_read(12'h400, 32'h00, "R9 dir read same cycle");

        settle(1);
        check("R8 idle rdata", bus_rdata, 32'h0);

        bus_write(12'h400, 32'h3C);
        bus_write(12'h3FC, 32'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears pad_oe", {24'h0, pad_oe}, 32'h0);
        check("R1 reset clears pad_out", {24'h0, pad_out}, 32'h0);
        settle(2);
        rst_n = 1'b1;
        settle(2);
        finish_run();
    end
endmodule